// File: doc/BRIEF.md
# Register-Mapped Signed Divider

This block is a small peripheral that divides a signed 32-bit dividend by a signed 16-bit divisor. Software stores the dividend, then stores the divisor. The divisor store starts the division and also sets a flag that shows whether that divisor was zero. The quotient is 32 bits and truncates toward zero. The remainder is 16 bits, takes the sign of the dividend, and is returned sign-extended to a full 32-bit word.

The bus is a plain synchronous register port with a byte offset, a write strobe, write data and read data. Read data comes from a register and is valid one cycle after the offset is presented. The core works on magnitudes and produces one quotient bit per clock. A `busy` output is high from the divisor store until both result registers have been updated together.

Top module: `mmio_sdiv`

## Requirements
- R1: After reset, every mapped register reads zero and `busy` is low.
- R2: Offset 0x00 is a 32-bit read-write dividend. A division takes the dividend value present at its start, so a later dividend write changes the read-back value but not the running result.
- R3: Offset 0x04 keeps the divisor in bits 15:0 and reads back zero-extended. A write with a nonzero value starts a division, and `busy` is high in the next cycle.
- R4: `busy` stays high for exactly 33 cycles after the divisor write edge. The quotient and the remainder change together, in the cycle where `busy` falls, and at no other time.
- R5: Offset 0x08 returns the two's complement quotient, truncated toward zero and taken modulo 2^32, so 0x80000000 divided by -1 gives 0x80000000.
- R6: Offset 0x0C returns the remainder. It has the sign of the dividend and a magnitude smaller than that of the divisor, with bits 31:16 all equal to bit 15.
- R7: Offset 0x10 is read-only status. Bit 1 is 1 when the last divisor written was zero, and every other bit reads 0. The flag changes only on a divisor write, and writes to 0x10 have no effect.
- R8: A zero divisor write performs no iteration: `busy` stays low and the quotient and remainder keep their previous values.
- R9: A divisor write while `busy` is high abandons the running division and starts again with the current dividend and the new divisor. `busy` then lasts 33 cycles from the new write.
- R10: Read data is registered, so it is valid one cycle after the offset is applied. Any offset other than the five mapped ones, including offsets that are not word-aligned, reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| busy | output | 1 | High while a division is running |

## Verification
The hardest case to reach is a restart in mid-division. The stimulus has to land a second divisor write inside the 33-cycle busy window and then show that nothing from the abandoned operands survives. The bench does this with a directed sequence: it starts a slow division, waits a fixed number of cycles, writes a new divisor, times the new busy window from that write, and compares the result against the new operands only. It uses the same approach for a dividend write during a run. Random signed operand pairs mixed with the overflow and extreme-sign corners cover the arithmetic.

// File: rtl/mmio_sdiv_pkg.sv
package mmio_sdiv_pkg;
  localparam int OFS_DIVIDEND = 'h00;
  localparam int OFS_DIVISOR  = 'h04;
  localparam int OFS_QUOT     = 'h08;
  localparam int OFS_REM      = 'h0C;
  localparam int OFS_STATUS   = 'h10;
  localparam int ZFLAG_BIT    = 1;
endpackage

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DVD_W-1:0] dvd,
  input  logic [DVS_W-1:0] dvs,
  output logic             run,
  output logic             fin,
  output logic [DVD_W-1:0] quo,
  output logic [DVS_W-1:0] rem
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [DVS_W-1:0] acc;
  logic [DVS_W-1:0] mag_b;
  logic [DVD_W-1:0] qsh;
  logic             neg_q, neg_r;

  logic [DVD_W-1:0] abs_a;
  logic [DVS_W-1:0] abs_b;
  logic [DVS_W:0]   trial, diff;
  logic             ge;
  logic [DVS_W-1:0] acc_nx;

  always_comb begin
    abs_a  = dvd[DVD_W-1] ? -dvd : dvd;
    abs_b  = dvs[DVS_W-1] ? -dvs : dvs;
    trial  = {acc, qsh[DVD_W-1]};
    ge     = trial >= {1'b0, mag_b};
    diff   = trial - {1'b0, mag_b};
    acc_nx = ge ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
    fin    = run && (cnt == '0);
    quo    = neg_q ? -qsh : qsh;
    rem    = neg_r ? -acc : acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      cnt   <= '0;
      acc   <= '0;
      mag_b <= '0;
      qsh   <= '0;
      neg_q <= 1'b0;
      neg_r <= 1'b0;
    end else if (start) begin
      run   <= |dvs;
      cnt   <= CNT_W'(DVD_W);
      acc   <= '0;
      mag_b <= abs_b;
      qsh   <= abs_a;
      neg_q <= dvd[DVD_W-1] ^ dvs[DVS_W-1];
      neg_r <= dvd[DVD_W-1];
    end else if (run) begin
      if (cnt == '0) begin
        run <= 1'b0;
      end else begin
        acc <= acc_nx;
        qsh <= {qsh[DVD_W-2:0], ge};
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R6
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> (acc < mag_b));

  // R4
  run_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && !start) |=> !run);
endmodule

// File: rtl/sdiv_rdmux.sv
module sdiv_rdmux
  import mmio_sdiv_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DVS_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dvd,
  input  logic [DVS_W-1:0]  dvs,
  input  logic [DATA_W-1:0] quo,
  input  logic [DATA_W-1:0] rem,
  input  logic              zflag,
  output logic [DATA_W-1:0] rd
);
  always_comb begin
    rd = '0;
    if (addr == ADDR_W'(OFS_DIVIDEND))      rd = dvd;
    else if (addr == ADDR_W'(OFS_DIVISOR))  rd = {{(DATA_W-DVS_W){1'b0}}, dvs};
    else if (addr == ADDR_W'(OFS_QUOT))     rd = quo;
    else if (addr == ADDR_W'(OFS_REM))      rd = rem;
    else if (addr == ADDR_W'(OFS_STATUS))   rd[ZFLAG_BIT] = zflag;
  end
endmodule

// File: rtl/mmio_sdiv.sv
module mmio_sdiv
  import mmio_sdiv_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DVS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy
);
  logic [DATA_W-1:0] dvd_q, quo_q, rem_q, rd_nx;
  logic [DVS_W-1:0]  dvs_q, core_rem;
  logic [DATA_W-1:0] core_quo;
  logic              zflag, core_fin, wr_dvd, wr_dvs;

  assign wr_dvd = bus_we && (bus_addr == ADDR_W'(OFS_DIVIDEND));
  assign wr_dvs = bus_we && (bus_addr == ADDR_W'(OFS_DIVISOR));

  sdiv_core #(.DVD_W(DATA_W), .DVS_W(DVS_W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .start (wr_dvs),
    .dvd   (dvd_q),
    .dvs   (bus_wdata[DVS_W-1:0]),
    .run   (busy),
    .fin   (core_fin),
    .quo   (core_quo),
    .rem   (core_rem)
  );

  sdiv_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DVS_W(DVS_W)) u_rdmux (
    .addr  (bus_addr),
    .dvd   (dvd_q),
    .dvs   (dvs_q),
    .quo   (quo_q),
    .rem   (rem_q),
    .zflag (zflag),
    .rd    (rd_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_q     <= '0;
      dvs_q     <= '0;
      quo_q     <= '0;
      rem_q     <= '0;
      zflag     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_nx;
      if (wr_dvd) dvd_q <= bus_wdata;
      if (wr_dvs) begin
        dvs_q <= bus_wdata[DVS_W-1:0];
        zflag <= ~|bus_wdata[DVS_W-1:0];
      end
      if (core_fin && !wr_dvs) begin
        quo_q <= core_quo;
        rem_q <= {{(DATA_W-DVS_W){core_rem[DVS_W-1]}}, core_rem};
      end
    end
  end

  // R8
  zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_dvs && bus_wdata[DVS_W-1:0] == '0) |=> (!busy && $stable(quo_q) && $stable(rem_q)));

  // R4
  pair_upd_chk: assert property (@(posedge clk) disable iff (rst)
    !core_fin |=> ($stable(quo_q) && $stable(rem_q)));

  // R7
  zflag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_dvs |=> $stable(zflag));

  // R6
  rem_sext_chk: assert property (@(posedge clk) disable iff (rst)
    rem_q[DATA_W-1:DVS_W] == {(DATA_W-DVS_W){rem_q[DVS_W-1]}});

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_dvs && bus_wdata[DVS_W-1:0] != '0) |=> busy);
endmodule

// File: tb/mmio_sdiv_test.sv
module mmio_sdiv_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mmio_sdiv uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] exp_q(input logic [31:0] a, input logic [15:0] b);
    longint la, lb, q;
    la = longint'($signed(a));
    lb = longint'($signed(b));
    q = la / lb;
    return q[31:0];
  endfunction

  function automatic logic [31:0] exp_r(input logic [31:0] a, input logic [15:0] b);
    longint la, lb, r;
    la = longint'($signed(a));
    lb = longint'($signed(b));
    r = la % lb;
    return r[31:0];
  endfunction

  task automatic do_div(input logic [31:0] a, input logic [15:0] b, input string tag);
    int n;
    logic [31:0] v;
    wr(5'h00, a);
    wr(5'h04, {16'h0, b});
    busy_len(n);
    chk({tag, " R4 busy length"}, 32'(n), 32'd33);
    rd(5'h08, v);
    chk({tag, " R5 quotient"}, v, exp_q(a, b));
    rd(5'h0C, v);
    chk({tag, " R6 remainder"}, v, exp_r(a, b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, q0, r0, a;
    logic [15:0] b;
    int n;
    int seed;
    seed = 17;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 busy", {31'h0, busy}, 32'h0);
    rd(5'h00, v); chk("R1 dividend", v, 32'h0);
    rd(5'h04, v); chk("R1 divisor", v, 32'h0);
    rd(5'h08, v); chk("R1 quotient", v, 32'h0);
    rd(5'h0C, v); chk("R1 remainder", v, 32'h0);
    rd(5'h10, v); chk("R1 status", v, 32'h0);

    // R2 / R3 read-back
    wr(5'h00, 32'hDEADBEEF);
    rd(5'h00, v); chk("R2 dividend readback", v, 32'hDEADBEEF);
    wr(5'h04, 32'hABCD8001);
    n = 0; if (busy) n = 1;
    chk("R3 busy after start", 32'(n), 32'd1);
    busy_len(n);
    rd(5'h04, v); chk("R3 divisor readback", v, 32'h00008001);

    // directed corners
    do_div(32'd100, 16'd7, "pos/pos");
    do_div(-32'sd100, 16'd7, "neg/pos");
    do_div(32'd100, -16'sd7, "pos/neg");
    do_div(-32'sd100, -16'sd7, "neg/neg");
    do_div(32'h80000000, 16'hFFFF, "overflow");
    do_div(32'h80000000, 16'h8000, "min/min");
    do_div(32'h7FFFFFFF, 16'h8000, "max/min");
    do_div(32'd5, 16'd9, "small");
    do_div(32'h7FFFFFFF, 16'd1, "unit");

    // R7 / R8 zero divisor
    do_div(32'd1234567, 16'd321, "pre-zero");
    rd(5'h08, q0); rd(5'h0C, r0);
    wr(5'h00, 32'd99);
    wr(5'h04, 32'hFFFF0000);
    chk("R8 busy stays low", {31'h0, busy}, 32'h0);
    rd(5'h08, v); chk("R8 quotient kept", v, q0);
    rd(5'h0C, v); chk("R8 remainder kept", v, r0);
    rd(5'h10, v); chk("R7 zero flag set", v, 32'h2);
    wr(5'h10, 32'hFFFFFFFF);
    rd(5'h10, v); chk("R7 status write ignored", v, 32'h2);
    wr(5'h04, 32'd3);
    rd(5'h10, v); chk("R7 zero flag cleared", v, 32'h0);
    busy_len(n);
    wr(5'h10, 32'hFFFFFFFF);
    rd(5'h10, v); chk("R7 status write ignored clear", v, 32'h0);

    // R9 restart mid-run
    wr(5'h00, 32'h12345678);
    wr(5'h04, 32'd3);
    repeat (10) @(negedge clk);
    wr(5'h00, -32'sd1000);
    wr(5'h04, {16'h0, -16'sd33});
    busy_len(n);
    chk("R9 busy from restart", 32'(n), 32'd33);
    rd(5'h08, v); chk("R9 quotient new operands", v, exp_q(-32'sd1000, -16'sd33));
    rd(5'h0C, v); chk("R9 remainder new operands", v, exp_r(-32'sd1000, -16'sd33));

    // R2 dividend write during run
    wr(5'h00, 32'd1000000);
    wr(5'h04, 32'd77);
    repeat (5) @(negedge clk);
    wr(5'h00, 32'd5);
    busy_len(n);
    rd(5'h08, v); chk("R2 quotient uses start dividend", v, exp_q(32'd1000000, 16'd77));
    rd(5'h00, v); chk("R2 dividend readback new", v, 32'd5);

    // R10 unmapped offsets
    rd(5'h14, v); chk("R10 offset 0x14", v, 32'h0);
    rd(5'h1C, v); chk("R10 offset 0x1C", v, 32'h0);
    rd(5'h02, v); chk("R10 unaligned 0x02", v, 32'h0);
    bus_addr = 5'h00;
    @(posedge clk); @(negedge clk);
    bus_addr = 5'h14;
    chk("R10 registered read timing", bus_rdata, 32'd5);

    // random operands
    for (int i = 0; i < 60; i++) begin
      a = $urandom();
      b = 16'($urandom());
      if (i % 7 == 0) b = 16'($urandom_range(1, 5));
      if (b == 16'h0) b = 16'h1;
      do_div(a, b, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule